// File: doc/BRIEF.md
# Fan Tachometer Monitor with Alerts

This block times the rotation of several cooling fans from their tachometer pulses and raises an alarm when a fan runs too slowly, stalls, or spins faster than allowed. The channels are visited one after another in a fixed round-robin order while monitoring is enabled. For the selected fan the block counts reference ticks across one full revolution (a set number of tach rising edges). The result is a period count: a larger count means a slower fan, and the all-ones value means no revolution finished in time, so the fan is treated as stalled.

Each finished count is stored per fan and compared with two programmable limits. A count above the fan's slow limit records an underspeed event. A count below its fast limit records an overspeed event. Events latch into status bits that clear when software reads them, and they latch again at the next measurement if the condition persists. Mask bits keep chosen status bits from pulling the active-low alert line, but the bits still record the event. Per-PWM enable bits let any latched underspeed request a forced maximum duty cycle.

A simple register port gives access to counts, limits, status, masks and fail-safe enables. With `NUM_FANS` = 4 the word addresses are: 0 to 3 counts, 4 to 7 slow limits, 8 to 11 fast limits, 12 status, 13 mask, 14 fail-safe enables.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every count reads 0, every slow limit reads all ones, every fast limit reads 0, status, mask and fail-safe enables read 0, `alert_n` is 1 and `force_max` is 0.
- R2: With tach period P clock cycles, a fan's count at address i (0 to `NUM_FANS`-1) reads floor(`PULSES_PER_REV`*P/`TICK_DIV`), counted from one rising edge to the `PULSES_PER_REV`-th rising edge after it.
- R3: When the count would exceed the all-ones value, or no rising edge arrives, the stored count is all ones.
- R4: While `mon_en` is 1, completed measurements go through channels 0,1,...,`NUM_FANS`-1 and then wrap to 0. While `mon_en` is 0, no count changes.
- R5: A measurement whose count is strictly greater than the fan's slow limit (address `NUM_FANS`+i) sets status bit i. A count equal to the limit does not set it.
- R6: A measurement whose count is strictly less than the fan's fast limit (address 2*`NUM_FANS`+i) sets status bit `NUM_FANS`+i. A count equal to the limit does not set it.
- R7: A read of the status word (address 3*`NUM_FANS`) returns its value and clears it. A bit sets again at the next measurement if its condition still holds. Writes to status are ignored.
- R8: A mask bit (address 3*`NUM_FANS`+1, same bit layout as status) set to 1 stops that status bit from driving `alert_n`, while the status bit still records the event.
- R9: `alert_n` is 0 exactly when some status bit is set whose mask bit is 0.
- R10: `force_max[j]` is 1 exactly when fail-safe enable bit j (address 3*`NUM_FANS`+2) is 1 and some underspeed status bit is set.
- R11: Limits, mask and fail-safe enables read back what was written. Read data appears on `reg_rdata` at the clock edge that samples `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Runs the measurement sequence while 1 |
| tach_in | input | NUM_FANS | Raw tachometer inputs, one per fan |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| alert_n | output | 1 | Active-low alert, meant for an open-drain pad |
| force_max | output | NUM_FANS | Per-PWM request to force maximum duty |

## Verification
On every cycle, the assertions check three things. Finished measurements must follow the round-robin channel order and stop while monitoring is off. An out-of-limit result must set the matching status bit on the next cycle. Status bits may drop only on a status read, and the alert and fail-safe outputs must stay quiet when status gives them no cause. The exact count for a given tach period, saturation on stalled or very slow fans, and the equal-to-limit boundaries can only be shown by the bench's scenarios. The same holds for clear-on-read followed by re-latching, the ignored status writes, and masking that hides a bit from the alert but not from a read.

// File: rtl/fan_mon_pkg.sv
package fan_mon_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_MEAS = 2'd2
  } seq_state_e;

  // saturating increment, stops at ceiling
  function automatic logic [31:0] sat_step(input logic [31:0] val, input logic [31:0] ceiling);
    return (val >= ceiling) ? ceiling : val + 32'd1;
  endfunction

  // slow fan: period count beyond the slow limit
  function automatic logic is_slow(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt > lim;
  endfunction

  // fast fan: period count below the fast limit
  function automatic logic is_fast(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt < lim;
  endfunction

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int NUM_FANS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] tach_in,
  output logic [NUM_FANS-1:0] rise
);

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= tach_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise[g] = sync_q & ~prev_q;
  end

endmodule

// File: rtl/tach_sequencer.sv
module tach_sequencer
  import fan_mon_pkg::*;
#(
  parameter int NUM_FANS       = 4,
  parameter int CNT_W          = 16,
  parameter int TICK_DIV       = 2778,
  parameter int PULSES_PER_REV = 2,
  localparam int CH_W  = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1,
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam int EDG_W = (PULSES_PER_REV > 1) ? $clog2(PULSES_PER_REV) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_en,
  input  logic [NUM_FANS-1:0] rise,
  output logic                meas_done,
  output logic [CH_W-1:0]     meas_chan,
  output logic [CNT_W-1:0]    meas_val
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_FANS - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [EDG_W-1:0] EDG_LAST = EDG_W'(PULSES_PER_REV - 1);

  seq_state_e       state_q;
  logic [CH_W-1:0]  chan_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EDG_W-1:0] edg_q;

  // named events for visibility
  logic             tick;
  logic             rise_sel;
  logic             cnt_full;
  logic             close_edge;
  logic [CNT_W-1:0] cnt_next;
  logic [PRE_W-1:0] pre_next;
  logic [CH_W-1:0]  chan_next;

  assign tick       = (pre_q == PRE_LAST);
  assign rise_sel   = rise[chan_q];
  assign cnt_full   = (cnt_q == CNT_MAX);
  assign close_edge = rise_sel && (edg_q == EDG_LAST);
  assign cnt_next   = tick ? CNT_W'(sat_step(32'(cnt_q), 32'(CNT_MAX))) : cnt_q;
  assign pre_next   = tick ? '0 : pre_q + PRE_W'(1);
  assign chan_next  = (chan_q == LAST_CH) ? '0 : chan_q + CH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      chan_q    <= '0;
      pre_q     <= '0;
      cnt_q     <= '0;
      edg_q     <= '0;
      meas_done <= 1'b0;
      meas_chan <= '0;
      meas_val  <= '0;
    end else begin
      meas_done <= 1'b0;
      if (!mon_en) begin
        state_q <= SEQ_IDLE;
        chan_q  <= '0;
        pre_q   <= '0;
        cnt_q   <= '0;
        edg_q   <= '0;
      end else begin
        unique case (state_q)
          SEQ_IDLE: begin
            state_q <= SEQ_ARM;
            pre_q   <= '0;
            cnt_q   <= '0;
            edg_q   <= '0;
          end
          SEQ_ARM: begin
            if (rise_sel) begin
              state_q <= SEQ_MEAS;
              pre_q   <= '0;
              cnt_q   <= '0;
              edg_q   <= '0;
            end else if (cnt_full) begin
              meas_done <= 1'b1;
              meas_val  <= CNT_MAX;
              meas_chan <= chan_q;
              chan_q    <= chan_next;
              state_q   <= SEQ_ARM;
              pre_q     <= '0;
              cnt_q     <= '0;
            end else begin
              pre_q <= pre_next;
              cnt_q <= cnt_next;
            end
          end
          SEQ_MEAS: begin
            if (close_edge || cnt_full) begin
              meas_done <= 1'b1;
              meas_val  <= close_edge ? cnt_next : CNT_MAX;
              meas_chan <= chan_q;
              chan_q    <= chan_next;
              state_q   <= SEQ_ARM;
              pre_q     <= '0;
              cnt_q     <= '0;
              edg_q     <= '0;
            end else begin
              pre_q <= pre_next;
              cnt_q <= cnt_next;
              if (rise_sel) edg_q <= edg_q + EDG_W'(1);
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fan_reg_file.sv
module fan_reg_file
  import fan_mon_pkg::*;
#(
  parameter int NUM_FANS = 4,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 4,
  localparam int CH_W    = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1,
  localparam int ST_W    = 2 * NUM_FANS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                meas_done,
  input  logic [CH_W-1:0]     meas_chan,
  input  logic [CNT_W-1:0]    meas_val,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [CNT_W-1:0]    reg_wdata,
  output logic [CNT_W-1:0]    reg_rdata,
  output logic [ST_W-1:0]     status_q,
  output logic [ST_W-1:0]     mask_q,
  output logic [NUM_FANS-1:0] fs_en_q,
  output logic                under_hit,
  output logic                over_hit
);

  localparam int CNT_BASE  = 0;
  localparam int MIN_BASE  = NUM_FANS;
  localparam int MAX_BASE  = 2 * NUM_FANS;
  localparam int STAT_ADDR = 3 * NUM_FANS;
  localparam int MASK_ADDR = 3 * NUM_FANS + 1;
  localparam int FS_ADDR   = 3 * NUM_FANS + 2;

  logic [CNT_W-1:0] cnt_q [NUM_FANS];
  logic [CNT_W-1:0] min_q [NUM_FANS];
  logic [CNT_W-1:0] max_q [NUM_FANS];

  logic             stat_clr;
  logic [ST_W-1:0]  set_vec;
  logic [CNT_W-1:0] rd_mux;

  assign under_hit = meas_done && is_slow(32'(meas_val), 32'(min_q[meas_chan]));
  assign over_hit  = meas_done && is_fast(32'(meas_val), 32'(max_q[meas_chan]));
  assign stat_clr  = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_FANS; i++) begin
      if (meas_chan == CH_W'(i)) begin
        set_vec[i]            = under_hit;
        set_vec[NUM_FANS + i] = over_hit;
      end
    end
  end

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        min_q[g] <= {CNT_W{1'b1}};
        max_q[g] <= '0;
      end else begin
        if (meas_done && meas_chan == CH_W'(g)) cnt_q[g] <= meas_val;
        if (reg_wr && reg_addr == ADDR_W'(MIN_BASE + g)) min_q[g] <= reg_wdata;
        if (reg_wr && reg_addr == ADDR_W'(MAX_BASE + g)) max_q[g] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      fs_en_q  <= '0;
    end else begin
      status_q <= (stat_clr ? '0 : status_q) | set_vec;
      if (reg_wr && reg_addr == ADDR_W'(MASK_ADDR)) mask_q  <= reg_wdata[ST_W-1:0];
      if (reg_wr && reg_addr == ADDR_W'(FS_ADDR))   fs_en_q <= reg_wdata[NUM_FANS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_FANS; i++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + i)) rd_mux = cnt_q[i];
      if (reg_addr == ADDR_W'(MIN_BASE + i)) rd_mux = min_q[i];
      if (reg_addr == ADDR_W'(MAX_BASE + i)) rd_mux = max_q[i];
    end
    if (reg_addr == ADDR_W'(STAT_ADDR)) rd_mux = CNT_W'(status_q);
    if (reg_addr == ADDR_W'(MASK_ADDR)) rd_mux = CNT_W'(mask_q);
    if (reg_addr == ADDR_W'(FS_ADDR))   rd_mux = CNT_W'(fs_en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int NUM_FANS       = 4,
  parameter int CNT_W          = 16,
  parameter int TICK_DIV       = 2778,
  parameter int PULSES_PER_REV = 2,
  parameter int ADDR_W         = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_en,
  input  logic [NUM_FANS-1:0] tach_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [CNT_W-1:0]    reg_wdata,
  output logic [CNT_W-1:0]    reg_rdata,
  output logic                alert_n,
  output logic [NUM_FANS-1:0] force_max
);

  localparam int CH_W = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1;
  localparam int ST_W = 2 * NUM_FANS;

  logic [NUM_FANS-1:0] rise;
  logic                meas_done;
  logic [CH_W-1:0]     meas_chan;
  logic [CNT_W-1:0]    meas_val;
  logic [ST_W-1:0]     status_q;
  logic [ST_W-1:0]     mask_q;
  logic [NUM_FANS-1:0] fs_en_q;
  logic                under_hit;
  logic                over_hit;
  logic                any_unmasked;
  logic                any_under;

  tach_edge_sync #(.NUM_FANS(NUM_FANS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tach_in (tach_in),
    .rise    (rise)
  );

  tach_sequencer #(
    .NUM_FANS       (NUM_FANS),
    .CNT_W          (CNT_W),
    .TICK_DIV       (TICK_DIV),
    .PULSES_PER_REV (PULSES_PER_REV)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .rise      (rise),
    .meas_done (meas_done),
    .meas_chan (meas_chan),
    .meas_val  (meas_val)
  );

  fan_reg_file #(
    .NUM_FANS (NUM_FANS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_done (meas_done),
    .meas_chan (meas_chan),
    .meas_val  (meas_val),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .fs_en_q   (fs_en_q),
    .under_hit (under_hit),
    .over_hit  (over_hit)
  );

  assign any_unmasked = |(status_q & ~mask_q);
  assign any_under    = |status_q[NUM_FANS-1:0];
  assign alert_n      = ~any_unmasked;
  assign force_max    = fs_en_q & {NUM_FANS{any_under}};

endmodule

// File: rtl/fan_mon_chk.sv
module fan_mon_chk #(
  parameter int NUM_FANS = 4,
  parameter int ADDR_W   = 4,
  localparam int CH_W    = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1,
  localparam int ST_W    = 2 * NUM_FANS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mon_en,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                meas_done,
  input logic [CH_W-1:0]     meas_chan,
  input logic                under_hit,
  input logic                over_hit,
  input logic [ST_W-1:0]     status_q,
  input logic [ST_W-1:0]     mask_q,
  input logic                alert_n,
  input logic [NUM_FANS-1:0] force_max
);

  logic            seen_q;
  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] want_ch;
  logic            stat_rd;

  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(3 * NUM_FANS));
  assign want_ch = (last_q == CH_W'(NUM_FANS - 1)) ? '0 : last_q + CH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (!mon_en) begin
      seen_q <= 1'b0;
    end else if (meas_done) begin
      seen_q <= 1'b1;
      last_q <= meas_chan;
    end
  end

  // R4: round-robin order of finished measurements
  p_chan_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && seen_q) |-> (meas_chan == want_ch));

  // R4: no measurement completes while monitoring is held off
  p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !$past(mon_en)) |-> !meas_done);

  // R5: slow result sets its underspeed bit next cycle
  p_under_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && under_hit) |=> status_q[$past(meas_chan)]);

  // R6: fast result sets its overspeed bit next cycle
  p_over_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && over_hit) |=> status_q[NUM_FANS + int'($past(meas_chan))]);

  // R7: status bits only drop on a status read
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: fully masked status never drives the alert
  p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> alert_n);

  // R9: alert only with some status bit set
  p_alert_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> (status_q != '0));

  // R10: forced duty only with a latched underspeed bit
  p_force_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max != '0) |-> (status_q[NUM_FANS-1:0] != '0));

endmodule

bind fan_tach_monitor fan_mon_chk #(
  .NUM_FANS (NUM_FANS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_en    (mon_en),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .meas_done (meas_done),
  .meas_chan (meas_chan),
  .under_hit (under_hit),
  .over_hit  (over_hit),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .alert_n   (alert_n),
  .force_max (force_max)
);

// File: tb/fan_tach_monitor_tb_top.sv
`timescale 1ns/1ps
module fan_tach_monitor_tb_top;

  localparam int NF   = 4;
  localparam int CW   = 8;
  localparam int TDIV = 2;
  localparam int PPR  = 2;
  localparam int AW   = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int A_MIN  = NF;
  localparam int A_MAX  = 2 * NF;
  localparam int A_STAT = 3 * NF;
  localparam int A_MASK = 3 * NF + 1;
  localparam int A_FS   = 3 * NF + 2;
  localparam int SLOW_LIM = 100;
  localparam int FAST_LIM = 20;
  localparam int NVEC = 4;
  // tach half-periods in clocks, 0 = stuck low
  localparam int VEC_HP [NVEC][NF] = '{
    '{20, 30, 40, 50},
    '{5, 60, 0, 150},
    '{8, 10, 45, 51},
    '{70, 25, 12, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mon_en = 1'b0;
  logic [NF-1:0] tach = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          alert_n;
  logic [NF-1:0] force_max;

  int hp [NF];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fan_tach_monitor #(
    .NUM_FANS (NF), .CNT_W (CW), .TICK_DIV (TDIV),
    .PULSES_PER_REV (PPR), .ADDR_W (AW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .mon_en (mon_en), .tach_in (tach),
    .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .alert_n (alert_n), .force_max (force_max)
  );

  for (genvar g = 0; g < NF; g++) begin : g_tach
    always begin
      if (hp[g] == 0) begin
        tach[g] = 1'b0;
        @(negedge clk);
      end else begin
        repeat (hp[g]) @(negedge clk);
        tach[g] = ~tach[g];
      end
    end
  end

  function automatic int exp_count(input int h);
    int v;
    if (h == 0) return CMAX;
    v = (PPR * 2 * h) / TDIV;
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int exp_status(input int h0, input int h1, input int h2, input int h3);
    int hs [NF];
    int st;
    hs = '{h0, h1, h2, h3};
    st = 0;
    for (int i = 0; i < NF; i++) begin
      if (exp_count(hs[i]) > SLOW_LIM) st |= (1 << i);
      if (exp_count(hs[i]) < FAST_LIM) st |= (1 << (NF + i));
    end
    return st;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    reg_addr  = AW'(addr);
    reg_wdata = CW'(data);
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input int addr, output int data);
    @(negedge clk);
    reg_addr = AW'(addr);
    reg_rd   = 1'b1;
    @(negedge clk);
    reg_rd   = 1'b0;
    data     = int'(reg_rdata);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rd;
    int st;
    for (int i = 0; i < NF; i++) hp[i] = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R1: reset values
    check("R1 alert_n", int'(alert_n), 1);
    check("R1 force_max", int'(force_max), 0);
    reg_read(0, rd);         check("R1 count0", rd, 0);
    reg_read(A_MIN + 2, rd); check("R1 slow limit", rd, CMAX);
    reg_read(A_MAX + 1, rd); check("R1 fast limit", rd, 0);
    reg_read(A_STAT, rd);    check("R1 status", rd, 0);
    reg_read(A_MASK, rd);    check("R1 mask", rd, 0);
    reg_read(A_FS, rd);      check("R1 failsafe", rd, 0);

    // R11: limit and control readback
    for (int i = 0; i < NF; i++) begin
      reg_write(A_MIN + i, SLOW_LIM);
      reg_write(A_MAX + i, FAST_LIM);
    end
    reg_read(A_MIN + 3, rd); check("R11 slow limit readback", rd, SLOW_LIM);
    reg_read(A_MAX + 0, rd); check("R11 fast limit readback", rd, FAST_LIM);
    reg_write(A_MASK, 8'hA5);
    reg_read(A_MASK, rd);    check("R11 mask readback", rd, 8'hA5);
    reg_write(A_MASK, 0);

    // vector table: R2 counts, R3 saturation, R5/R6 limits, R9 alert
    mon_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < NF; i++) hp[i] = VEC_HP[v][i];
      wait_clk(9000);
      reg_read(A_STAT, rd);
      wait_clk(5000);
      st = exp_status(VEC_HP[v][0], VEC_HP[v][1], VEC_HP[v][2], VEC_HP[v][3]);
      check("R9 alert level", int'(alert_n), (st != 0) ? 0 : 1);
      for (int i = 0; i < NF; i++) begin
        reg_read(i, rd);
        if (VEC_HP[v][i] == 0 || exp_count(VEC_HP[v][i]) == CMAX)
          check("R3 saturated count", rd, exp_count(VEC_HP[v][i]));
        else
          check("R2 period count", rd, exp_count(VEC_HP[v][i]));
      end
      reg_read(A_STAT, rd);
      check("R5 R6 status bits", rd, st);
    end

    // last vector leaves status 0x09 (fan0 slow, fan3 stalled)
    st = exp_status(VEC_HP[3][0], VEC_HP[3][1], VEC_HP[3][2], VEC_HP[3][3]);
    wait_clk(5000);
    mon_en = 1'b0;
    wait_clk(10);
    reg_write(A_STAT, 0);
    reg_read(A_STAT, rd);  check("R7 write ignored", rd, st);
    reg_read(A_STAT, rd);  check("R7 cleared by read", rd, 0);
    check("R9 alert released", int'(alert_n), 1);

    // R4: counts frozen while monitoring is off
    for (int i = 0; i < NF; i++) hp[i] = 33;
    wait_clk(3000);
    reg_read(1, rd);       check("R4 frozen count", rd, exp_count(VEC_HP[3][1]));
    reg_read(A_STAT, rd);  check("R4 no status while off", rd, 0);
    for (int i = 0; i < NF; i++) hp[i] = VEC_HP[3][i];
    mon_en = 1'b1;
    wait_clk(9000);
    check("R7 set again alert", int'(alert_n), 0);

    // R8: masking hides from alert, status still records
    reg_write(A_MASK, st);
    check("R8 masked alert", int'(alert_n), 1);
    reg_read(A_STAT, rd);  check("R7 R8 status re-set and recorded", rd, st);
    wait_clk(5000);
    reg_write(A_MASK, 8'h01);
    check("R8 partial mask alert", int'(alert_n), 0);

    // R10: fail-safe enables
    reg_write(A_FS, 4'b0101);
    check("R10 force with underspeed", int'(force_max), 4'b0101);
    reg_write(A_FS, 0);
    check("R10 force disabled", int'(force_max), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule